// File: doc/BRIEF.md
# Wide-Path Extension Target for a Parallel Local Bus

This block is the target-side handler for the upper half of a 64-bit parallel bus with multiplexed address and data. When reset ends it records whether the slot it sits in carries the wide extension. For every transaction it decides whether to grant a 64-bit data path and signals that grant on the active-low ACK64# line.

It builds a 64-bit address in one of two ways. The first is a two-phase dual address cycle. The second is a single wide address phase that carries both halves at once. During data beats it merges the upper data lanes and the upper byte enables when the wide path is in use. It also checks the delayed even parity bit that covers the upper lanes.

The inputs are the bus signals as simple sampled levels. The outputs are the decoded address, the command, the beat data, the byte enables and a parity-error pulse. The block claims every transaction it sees. Address decoding, arbitration, configuration space and retry handling belong elsewhere.

Top module: `pci64x_target`

## Requirements
- R1: Reset (`rst_n` low) holds `ack64_n` high and `addr_valid_o`, `beat_valid_o`, `perr_o` low. The block samples `req64_n` while in reset and keeps the value it had at the last clock before release. If `req64_n` was high at that point, `ack64_n` stays high until the next reset.
- R2: In a 64-bit slot, `ack64_n` goes low one clock after the final address phase when two conditions hold in that phase. First, `req64_n` is low. Second, the command is a memory command: 0110 read, 0111 write, 1100 read multiple, 1110 read line, or 1111 write-and-invalidate.
- R3: Any command that is not one of those memory codes leaves `ack64_n` high for the whole transaction. Examples are 0010, 0011 and 1010.
- R4: Once low, `ack64_n` stays low until a data-period clock in which `frame_n` and `irdy_n` are both high. It is high from the next clock on.
- R5: An address phase with `cbe_n[3:0]`=1101 that is not a wide single phase (see R6) has two parts. It stores `ad[31:0]` as the low address half. The next clock is the second address phase, which supplies the high half on `ad[31:0]` and the real command on `cbe_n[3:0]`. `addr_valid_o` pulses one clock after that second phase.
- R6: In a 64-bit slot, an address phase with `cbe_n[3:0]`=1101 and `req64_n` low is a complete address on its own. `addr_o` takes `ad[63:0]` and `cmd_o` takes `cbe_n[7:4]`. `addr_valid_o` pulses one clock later.
- R7: Any other first address phase gives `addr_o` = {32 zero bits, `ad[31:0]`} and `cmd_o` = `cbe_n[3:0]`. `addr_valid_o` pulses one clock later.
- R8: A data-period clock with `irdy_n` and `trdy_n` both low is a beat. `beat_valid_o` pulses one clock later. `wdata_o` is `ad` and `be_o` is the bitwise inverse of `cbe_n` (active high) on a wide beat. On a narrow beat, bits 63:32 of `wdata_o` and bits 7:4 of `be_o` are zero.
- R9: `wide_beat_o` marks a beat taken while both `req64_n` and `ack64_n` were low.
- R10: After a phase that used the upper lanes (a wide beat or an R6 address phase), `par64` in the following clock must equal the XOR of that phase's `ad[63:32]`. A mismatch raises `perr_o` for one clock, one clock after the `par64` clock.
- R11: `par64` that follows a phase which did not use the upper lanes is never checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus reset, active low |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| req64_n | input | 1 | Master wide request, active low |
| ad | input | 64 | Multiplexed address/data lanes |
| cbe_n | input | 8 | Command / byte enables, active low |
| par64 | input | 1 | Even parity over ad[63:32], one clock late |
| ack64_n | output | 1 | Wide grant, active low |
| addr_o | output | 64 | Assembled transaction address |
| cmd_o | output | 4 | Transaction command |
| addr_valid_o | output | 1 | Address/command update pulse |
| wdata_o | output | 64 | Beat data |
| be_o | output | 8 | Beat byte enables, active high |
| beat_valid_o | output | 1 | Beat pulse |
| wide_beat_o | output | 1 | Beat used the upper lanes |
| perr_o | output | 1 | Upper-lane parity error pulse |

## Verification
The bench checks that the wide path is refused after a reset taken with `req64_n` high. A design that latched the width continuously would grant it mid-run. Dual address cycles are driven both as one wide phase and as two narrow phases. This catches a design that swaps the halves or takes the command from the wrong nibble. Parity errors are injected both after wide phases and after narrow ones. A checker that looks at every phase, or that is off by one clock, reports spurious or misplaced `perr_o` pulses. Non-memory commands driven with `req64_n` low expose a design that grants the wide path without decoding the command.

// File: rtl/pci64x_pkg.sv
package pci64x_pkg;
  localparam int LANE_W = 32;
  localparam int LANES  = 2;
  localparam int BUS_W  = LANE_W * LANES;
  localparam int BE_W   = BUS_W / 8;
  localparam int LBE_W  = LANE_W / 8;
  localparam int CMD_W  = 4;

  localparam logic [CMD_W-1:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [CMD_W-1:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [CMD_W-1:0] CMD_MEM_RDM = 4'b1100;
  localparam logic [CMD_W-1:0] CMD_DUALADR = 4'b1101;
  localparam logic [CMD_W-1:0] CMD_MEM_RDL = 4'b1110;
  localparam logic [CMD_W-1:0] CMD_MEM_WRI = 4'b1111;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ADR_HI = 2'd1,
    ST_DATA   = 2'd2
  } tgt_state_e;

  function automatic logic is_mem_cmd(input logic [CMD_W-1:0] c);
    return (c == CMD_MEM_RD) || (c == CMD_MEM_WR) || (c == CMD_MEM_RDM) ||
           (c == CMD_MEM_RDL) || (c == CMD_MEM_WRI);
  endfunction

  function automatic logic lane_parity(input logic [LANE_W-1:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/pci64x_width_latch.sv
module pci64x_width_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req64_n,
  output logic slot64
);
  // Follows REQ64# while reset is held; frozen from release on.
  always_ff @(posedge clk) begin
    if (!rst_n) slot64 <= !req64_n;
  end
endmodule

// File: rtl/pci64x_addr_ctrl.sv
module pci64x_addr_ctrl
  import pci64x_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot64,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              req64_n,
  input  logic [BUS_W-1:0]  ad,
  input  logic [BE_W-1:0]   cbe_n,
  output logic              ack64_n,
  output logic              in_data,
  output logic [BUS_W-1:0]  addr_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              addr_valid_o,
  output logic              wide_addr_ph
);
  tgt_state_e         st_q;
  logic [LANE_W-1:0]  lo_q;

  logic               addr_ph, is_dual, final_addr, grant_wide, xfer_end;
  logic [CMD_W-1:0]   next_cmd;
  logic [BUS_W-1:0]   next_addr;

  assign addr_ph      = (st_q == ST_IDLE) && !frame_n;
  assign is_dual      = (cbe_n[CMD_W-1:0] == CMD_DUALADR);
  assign wide_addr_ph = addr_ph && is_dual && slot64 && !req64_n;
  assign final_addr   = (addr_ph && (!is_dual || wide_addr_ph)) || (st_q == ST_ADR_HI);
  assign xfer_end     = (st_q == ST_DATA) && frame_n && irdy_n;
  assign in_data      = (st_q == ST_DATA);

  always_comb begin
    next_cmd  = cbe_n[CMD_W-1:0];
    next_addr = {{(BUS_W-LANE_W){1'b0}}, ad[LANE_W-1:0]};
    if (wide_addr_ph) begin
      next_cmd  = cbe_n[BE_W-1:BE_W-CMD_W];
      next_addr = ad;
    end else if (st_q == ST_ADR_HI) begin
      next_addr = {ad[LANE_W-1:0], lo_q};
    end
  end

  assign grant_wide = final_addr && slot64 && !req64_n && is_mem_cmd(next_cmd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      lo_q         <= '0;
      ack64_n      <= 1'b1;
      addr_o       <= '0;
      cmd_o        <= '0;
      addr_valid_o <= 1'b0;
    end else begin
      addr_valid_o <= final_addr;
      if (final_addr) begin
        st_q    <= ST_DATA;
        addr_o  <= next_addr;
        cmd_o   <= next_cmd;
        ack64_n <= !grant_wide;
      end else if (addr_ph && is_dual) begin
        st_q <= ST_ADR_HI;
        lo_q <= ad[LANE_W-1:0];
      end else if (xfer_end) begin
        st_q    <= ST_IDLE;
        ack64_n <= 1'b1;
      end
    end
  end

  assert_narrow_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !slot64 |-> ack64_n);
  assert_ack_mem_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ack64_n |-> is_mem_cmd(cmd_o));
  assert_ack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack64_n && !(frame_n && irdy_n)) |=> !ack64_n);
  assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack64_n && frame_n && irdy_n) |=> ack64_n);
endmodule

// File: rtl/pci64x_data_merge.sv
module pci64x_data_merge
  import pci64x_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_data,
  input  logic              ack64_n,
  input  logic              req64_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic [BUS_W-1:0]  ad,
  input  logic [BE_W-1:0]   cbe_n,
  output logic [BUS_W-1:0]  wdata_o,
  output logic [BE_W-1:0]   be_o,
  output logic              beat_valid_o,
  output logic              wide_beat_o,
  output logic              wide_beat_ph
);
  logic beat_ph;
  logic [LANES-1:0]  lane_on;
  logic [BUS_W-1:0]  data_m;
  logic [BE_W-1:0]   be_m;

  assign beat_ph      = in_data && !irdy_n && !trdy_n;
  assign wide_beat_ph = beat_ph && !ack64_n && !req64_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_base
      assign lane_on[g] = 1'b1;
    end else begin : g_ext
      assign lane_on[g] = wide_beat_ph;
    end
    assign data_m[g*LANE_W +: LANE_W] = lane_on[g] ? ad[g*LANE_W +: LANE_W] : '0;
    assign be_m[g*LBE_W +: LBE_W]     = lane_on[g] ? ~cbe_n[g*LBE_W +: LBE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdata_o      <= '0;
      be_o         <= '0;
      beat_valid_o <= 1'b0;
      wide_beat_o  <= 1'b0;
    end else begin
      beat_valid_o <= beat_ph;
      wide_beat_o  <= wide_beat_ph;
      if (beat_ph) begin
        wdata_o <= data_m;
        be_o    <= be_m;
      end
    end
  end

  assert_narrow_upper_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !wide_beat_o) |-> (be_o[BE_W-1:LBE_W] == '0 && wdata_o[BUS_W-1:LANE_W] == '0));
  assert_wide_needs_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wide_beat_o |-> $past(!ack64_n));
endmodule

// File: rtl/pci64x_par_check.sv
module pci64x_par_check
  import pci64x_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upper_used,
  input  logic [LANE_W-1:0] ad_hi,
  input  logic              par64,
  output logic              perr_o
);
  logic pend_q, exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      exp_q  <= 1'b0;
      perr_o <= 1'b0;
    end else begin
      pend_q <= upper_used;
      exp_q  <= lane_parity(ad_hi);
      perr_o <= pend_q && (par64 != exp_q);
    end
  end

  assert_perr_after_wide_R11: assert property (@(posedge clk) disable iff (!rst_n)
    perr_o |-> $past(upper_used, 2));
endmodule

// File: rtl/pci64x_target.sv
module pci64x_target
  import pci64x_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic              req64_n,
  input  logic [BUS_W-1:0]  ad,
  input  logic [BE_W-1:0]   cbe_n,
  input  logic              par64,
  output logic              ack64_n,
  output logic [BUS_W-1:0]  addr_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              addr_valid_o,
  output logic [BUS_W-1:0]  wdata_o,
  output logic [BE_W-1:0]   be_o,
  output logic              beat_valid_o,
  output logic              wide_beat_o,
  output logic              perr_o
);
  logic slot64, in_data, wide_addr_ph, wide_beat_ph, upper_used;

  pci64x_width_latch u_width (
    .clk(clk), .rst_n(rst_n), .req64_n(req64_n), .slot64(slot64)
  );

  pci64x_addr_ctrl u_addr (
    .clk(clk), .rst_n(rst_n), .slot64(slot64), .frame_n(frame_n), .irdy_n(irdy_n),
    .req64_n(req64_n), .ad(ad), .cbe_n(cbe_n), .ack64_n(ack64_n), .in_data(in_data),
    .addr_o(addr_o), .cmd_o(cmd_o), .addr_valid_o(addr_valid_o),
    .wide_addr_ph(wide_addr_ph)
  );

  pci64x_data_merge u_data (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .ack64_n(ack64_n), .req64_n(req64_n),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .ad(ad), .cbe_n(cbe_n), .wdata_o(wdata_o),
    .be_o(be_o), .beat_valid_o(beat_valid_o), .wide_beat_o(wide_beat_o),
    .wide_beat_ph(wide_beat_ph)
  );

  assign upper_used = wide_addr_ph || wide_beat_ph;

  pci64x_par_check u_par (
    .clk(clk), .rst_n(rst_n), .upper_used(upper_used),
    .ad_hi(ad[BUS_W-1:LANE_W]), .par64(par64), .perr_o(perr_o)
  );

  assert_phase_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wide_addr_ph && wide_beat_ph));
endmodule

// File: tb/pci64x_target_test.sv
module pci64x_target_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, req64_n = 1'b1, par64 = 1'b0;
  logic [63:0] ad = '0;
  logic [7:0]  cbe_n = '1;
  logic        ack64_n, addr_valid_o, beat_valid_o, wide_beat_o, perr_o;
  logic [63:0] addr_o, wdata_o;
  logic [3:0]  cmd_o;
  logic [7:0]  be_o;

  int checks = 0, errors = 0;

  // bench reference state
  int          m_st = 0;
  logic        m_slot = 1'b0, m_ack_n = 1'b1, m_pchk = 1'b0, m_ppar = 1'b0;
  logic [31:0] m_lo = '0, prev_hi = '0;

  always #10 clk = ~clk;

  pci64x_target uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .req64_n(req64_n), .ad(ad), .cbe_n(cbe_n), .par64(par64), .ack64_n(ack64_n),
    .addr_o(addr_o), .cmd_o(cmd_o), .addr_valid_o(addr_valid_o), .wdata_o(wdata_o),
    .be_o(be_o), .beat_valid_o(beat_valid_o), .wide_beat_o(wide_beat_o), .perr_o(perr_o)
  );

  function automatic logic mem_code(input logic [3:0] c);
    case (c)
      4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic even_bit(input logic [31:0] v);
    logic p = 1'b0;
    for (int k = 0; k < 32; k++) p = p ^ v[k];
    return p;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic f, input logic i, input logic t, input logic [63:0] d,
                      input logic [7:0] c, input logic r, input logic inj);
    logic e_av, e_beat, e_wide, e_perr, up;
    logic [63:0] e_addr, e_wd;
    logic [7:0]  e_be;
    logic [3:0]  e_cmd;
    string atag, ptag, ktag;
    frame_n = f; irdy_n = i; trdy_n = t; ad = d; cbe_n = c; req64_n = r;
    par64 = even_bit(prev_hi) ^ inj;
    prev_hi = d[63:32];
    e_av = 0; e_beat = 0; e_wide = 0; up = 0; e_addr = '0; e_wd = '0; e_be = '0;
    e_cmd = '0; atag = "R7";
    e_perr = m_pchk && (par64 != m_ppar);
    ptag = m_pchk ? "R10" : "R11";
    if (m_st == 0) begin
      if (!f) begin
        if (c[3:0] == 4'b1101 && m_slot && !r) begin
          e_addr = d; e_cmd = c[7:4]; e_av = 1; up = 1; atag = "R6";
        end else if (c[3:0] == 4'b1101) begin
          m_lo = d[31:0]; m_st = 1;
        end else begin
          e_addr = {32'h0, d[31:0]}; e_cmd = c[3:0]; e_av = 1; atag = "R7";
        end
      end
    end else if (m_st == 1) begin
      e_addr = {d[31:0], m_lo}; e_cmd = c[3:0]; e_av = 1; atag = "R5";
    end else begin
      if (!i && !t) begin
        e_beat = 1;
        e_wide = !m_ack_n && !r;
        up = e_wide;
        e_wd = e_wide ? d : {32'h0, d[31:0]};
        e_be = e_wide ? ~c : {4'h0, ~c[3:0]};
      end
      if (f && i) begin m_st = 0; m_ack_n = 1; end
    end
    if (e_av) begin
      m_st = 2;
      m_ack_n = !(m_slot && !r && mem_code(e_cmd));
    end
    m_pchk = up;
    m_ppar = even_bit(d[63:32]);
    if (!m_slot) ktag = "R1 ack64_n";
    else ktag = "R2/R4 ack64_n";
    @(posedge clk); @(negedge clk);
    check(ktag, 64'(ack64_n), 64'(m_ack_n));
    check({atag, " addr_valid"}, 64'(addr_valid_o), 64'(e_av));
    if (e_av) begin
      check({atag, " addr"}, addr_o, e_addr);
      check({atag, " cmd"}, 64'(cmd_o), 64'(e_cmd));
    end
    check("R8 beat_valid", 64'(beat_valid_o), 64'(e_beat));
    if (e_beat) begin
      check("R8 wdata", wdata_o, e_wd);
      check("R8 be", 64'(be_o), 64'(e_be));
      check("R9 wide_beat", 64'(wide_beat_o), 64'(e_wide));
    end
    check({ptag, " perr"}, 64'(perr_o), 64'(e_perr));
  endtask

  task automatic do_reset(input logic r);
    rst_n = 0; frame_n = 1; irdy_n = 1; trdy_n = 1; req64_n = r; par64 = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    m_slot = !r; m_st = 0; m_ack_n = 1; m_pchk = 0; prev_hi = ad[63:32];
    @(negedge clk);
    check("R1 reset ack64_n", 64'(ack64_n), 64'h1);
    check("R1 reset addr_valid", 64'(addr_valid_o), 64'h0);
    check("R1 reset beat_valid", 64'(beat_valid_o), 64'h0);
    check("R1 reset perr", 64'(perr_o), 64'h0);
  endtask

  // cmd: code on cbe[3:0] in first phase; real: command for dual cycles
  task automatic txn(input logic [3:0] cmd, input logic [3:0] real_cmd, input logic r,
                     input int beats, input int waits, input int inj_pct);
    logic [63:0] a = {$urandom, $urandom};
    if (cmd == 4'b1101) begin
      step(0, 1, 1, a, {real_cmd, 4'b1101}, r, 1'b0);
      if (!(m_slot && !r))
        step(0, 1, 1, {32'h0, a[63:32]}, {4'hF, real_cmd}, r, 1'b0);
    end else begin
      step(0, 1, 1, a, {4'($urandom), cmd}, r, 1'b0);
    end
    for (int b = 0; b < beats; b++) begin
      for (int w = 0; w < waits; w++)
        step(0, 0, 1, {$urandom, $urandom}, 8'($urandom), r, ($urandom % 100) < inj_pct);
      step(b == beats - 1, 0, 0, {$urandom, $urandom}, 8'($urandom), r,
           ($urandom % 100) < inj_pct);
    end
    step(1, 1, 1, {$urandom, $urandom}, 8'hFF, 1'b1, ($urandom % 100) < inj_pct);
    step(1, 1, 1, {$urandom, $urandom}, 8'hFF, 1'b1, ($urandom % 100) < inj_pct);
  endtask

  function automatic logic [3:0] pick_cmd(input int k);
    case (k % 9)
      0: return 4'b0110; 1: return 4'b0111; 2: return 4'b1100;
      3: return 4'b1110; 4: return 4'b1111; 5: return 4'b0010;
      6: return 4'b0011; 7: return 4'b1010; default: return 4'b1101;
    endcase
  endfunction

  task automatic random_run(input int n);
    for (int k = 0; k < n; k++) begin
      logic [3:0] c = pick_cmd($urandom);
      logic [3:0] rc = pick_cmd($urandom % 8);
      txn(c, rc, 1'($urandom), 1 + ($urandom % 4), $urandom % 2, 15);
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    // 64-bit slot
    do_reset(1'b0);
    txn(4'b0111, 4'h0, 1'b0, 3, 1, 0);      // R2 wide memory write
    txn(4'b0110, 4'h0, 1'b1, 2, 0, 0);      // R8 narrow read, no request
    txn(4'b0011, 4'h0, 1'b0, 2, 0, 100);    // R3 I/O write, R11 parity ignored
    txn(4'b1101, 4'b1111, 1'b0, 2, 0, 100); // R6 single wide address, R10 errors
    txn(4'b1101, 4'b0110, 1'b1, 1, 1, 0);   // R5 two-phase address
    txn(4'b1100, 4'h0, 1'b0, 4, 0, 50);     // R4 long burst with mixed parity
    random_run(150);
    // 32-bit slot
    do_reset(1'b1);
    txn(4'b0111, 4'h0, 1'b0, 2, 0, 100);    // R1 no grant, R11
    txn(4'b1101, 4'b1110, 1'b0, 2, 0, 0);   // R5 request ignored for address
    random_run(80);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule